// File: doc/BRIEF.md
# Gate Command Input Qualifier

This block turns three asynchronous logic-level control inputs into one registered gate-on command for a single power switch. The inputs are a non-inverting command, an inverting command and an active-low shutdown. Each one crosses into the local clock through a multi-flop synchroniser. It then passes a minimum-pulse-width filter, so that a short glitch can never reach the switch. The filtered levels are combined so that the switch is on only when the non-inverting command is high, the inverting command is low and shutdown is not requested. A force-off request from the protection logic (undervoltage or internal error) overrides everything.

The same logic serves both control modes without configuration. For non-inverting control, tie the inverting input low and drive the non-inverting one. For inverting control, tie the non-inverting input high and drive the inverting one. Filter lengths are set in clock cycles by parameters, one for the two command inputs and one for the shutdown input.

Each filter is a two-state machine. In FLT_HOLD it holds the accepted level. In FLT_COUNT it counts the cycles in which the synchronised input differs from that level. It moves FLT_HOLD to FLT_COUNT when the input differs. It moves FLT_COUNT to FLT_HOLD in two cases: when the input returns to the held level (the count is abandoned), or when the count completes (the level is accepted). The gate machine has three states: GATE_OFF, GATE_ON and GATE_FORCED. GATE_OFF goes to GATE_ON when the combined request is true. GATE_ON goes to GATE_OFF when the request drops. Any state goes to GATE_FORCED when force-off is seen. GATE_FORCED always returns to GATE_OFF once force-off is released.

Top module: `gcq_top`

## Requirements
- R1: `gate_on` is high only in cycles where the qualified levels satisfy in_pos = 1, in_neg = 0 and shutdown_n = 1, and no force-off was seen at the previous clock edge.
- R2: With in_neg held at 0, in_pos alone controls `gate_on`. With in_pos held at 1, in_neg alone controls it, with inverted sense.
- R3: A level on in_pos or in_neg is accepted only after it has been seen for FILT_LEN consecutive synchronised cycles. A pulse shorter than that never changes `gate_on`. After an accepted input edge, `gate_on` changes at the (FILT_LEN+3)-th rising clock edge (2 synchroniser stages, FILT_LEN filter cycles, 1 gate register).
- R4: shutdown_n has its own filter of EN_FILT_LEN cycles. A shorter low pulse is ignored. A qualified low turns `gate_on` off.
- R5: `gate_on` is low after the first rising clock edge at which force_off is high, whatever the other inputs are doing.
- R6: After force_off falls, `gate_on` stays low for at least one more cycle (GATE_FORCED always passes through GATE_OFF).
- R7: Asynchronous reset (rst_n low) holds `gate_on` low and loads the safe levels: in_pos 0, in_neg 1, shutdown_n 0. After release, with steady on-inputs, `gate_on` rises at the (max(FILT_LEN, EN_FILT_LEN)+3)-th edge.
- R8: A return to the held level during counting restarts the count. For example, with FILT_LEN = 4, the pattern high for 3 cycles, low for 1, high for 3 never turns the gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pos | input | 1 | Non-inverting command (asynchronous) |
| in_neg | input | 1 | Inverting command (asynchronous) |
| shutdown_n | input | 1 | Active-low shutdown (asynchronous) |
| force_off | input | 1 | Synchronous force-off from the protection logic |
| gate_on | output | 1 | Registered gate-on command |

## Verification
Directed patterns measure the exact latency of an accepted edge in both control modes. Pulses of FILT_LEN-1 and FILT_LEN cycles separate suppression from acceptance, and an interrupted run separates a restarting count from an accumulating one. Short and long shutdown pulses, and single-cycle force-off pulses on an active gate, tell apart the override, the extra off cycle on recovery and the enable filter. A seeded random phase then runs in three segments: non-inverting mode, inverting mode, and all inputs free. Every cycle is compared with a bench model built from the requirements, which exposes mixed toggling that the directed cases miss.

// File: rtl/gcq_pkg.sv
package gcq_pkg;

    // Pulse-width filter states
    typedef enum logic [0:0] {
        FLT_HOLD  = 1'b0,
        FLT_COUNT = 1'b1
    } flt_state_e;

    // Gate command states
    typedef enum logic [1:0] {
        GATE_OFF    = 2'd0,
        GATE_ON     = 2'd1,
        GATE_FORCED = 2'd2
    } gate_state_e;

    // Channel indices of the qualified input vector
    localparam int CH_POS  = 0;
    localparam int CH_NEG  = 1;
    localparam int CH_RUN  = 2;
    localparam int NUM_CH  = 3;

    // Safe level each channel holds out of reset: pos low, neg high, shutdown active
    localparam logic [NUM_CH-1:0] CH_SAFE = 3'b010;

endpackage

// File: rtl/gcq_sync.sv
module gcq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // First stage samples the asynchronous pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= RST_VAL;
        end else begin
            chain[0] <= d;
        end
    end

    // Remaining stages
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= RST_VAL;
            end else begin
                chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gcq_filter.sv
module gcq_filter
    import gcq_pkg::*;
#(
    parameter int   LEN     = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    output logic q
);

    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    flt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          level_q, level_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            level_q <= RST_VAL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        level_d = level_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (s != level_q) begin
                    if (LEN < 2) begin
                        level_d = s;
                    end else begin
                        state_d = FLT_COUNT;
                        cnt_d   = CW'(1);
                    end
                end
            end
            FLT_COUNT: begin
                if (s == level_q) begin
                    // run broken: drop the count
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    level_d = s;
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = FLT_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // Output
    always_comb begin
        q = level_q;
    end

endmodule

// File: rtl/gcq_gate_fsm.sv
module gcq_gate_fsm
    import gcq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pos_q,
    input  logic neg_q,
    input  logic run_q,
    input  logic force_off,
    output logic gate_on
);

    gate_state_e state_q, state_d;
    logic        request;

    assign request = pos_q & ~neg_q & run_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (force_off) begin
            state_d = GATE_FORCED;
        end else begin
            unique case (state_q)
                GATE_OFF:    if (request)  state_d = GATE_ON;
                GATE_ON:     if (!request) state_d = GATE_OFF;
                GATE_FORCED: state_d = GATE_OFF;
                default:     state_d = GATE_OFF;
            endcase
        end
    end

    // Output
    always_comb begin
        gate_on = (state_q == GATE_ON);
    end

endmodule

// File: rtl/gcq_top.sv
module gcq_top
    import gcq_pkg::*;
#(
    parameter int FILT_LEN    = 4,
    parameter int EN_FILT_LEN = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_pos,
    input  logic in_neg,
    input  logic shutdown_n,
    input  logic force_off,
    output logic gate_on
);

    logic [NUM_CH-1:0] raw_lvl;
    logic [NUM_CH-1:0] sync_lvl;
    logic [NUM_CH-1:0] flt_lvl;

    assign raw_lvl[CH_POS] = in_pos;
    assign raw_lvl[CH_NEG] = in_neg;
    assign raw_lvl[CH_RUN] = shutdown_n;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int CH_LEN = (g == CH_RUN) ? EN_FILT_LEN : FILT_LEN;

        gcq_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (CH_SAFE[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lvl[g]),
            .q     (sync_lvl[g])
        );

        gcq_filter #(
            .LEN     (CH_LEN),
            .RST_VAL (CH_SAFE[g])
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .s     (sync_lvl[g]),
            .q     (flt_lvl[g])
        );
    end

    gcq_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_q     (flt_lvl[CH_POS]),
        .neg_q     (flt_lvl[CH_NEG]),
        .run_q     (flt_lvl[CH_RUN]),
        .force_off (force_off),
        .gate_on   (gate_on)
    );

endmodule

// File: rtl/gcq_checker.sv
module gcq_checker (
    input logic clk,
    input logic rst_n,
    input logic force_off,
    input logic gate_on,
    input logic pos_s,
    input logic pos_q,
    input logic neg_q,
    input logic run_q
);

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> !gate_on);  // R5

    AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> $past(pos_q && !neg_q && run_q && !force_off));  // R1

    AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !gate_on);  // R4

    AST_RECOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |-> !$past(force_off, 2));  // R6

    AST_FILTER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_q) |-> (pos_q == $past(pos_s)));  // R3

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_OFF: assert (!gate_on);  // R7
        end
    end

endmodule

bind gcq_top gcq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_off (force_off),
    .gate_on   (gate_on),
    .pos_s     (sync_lvl[0]),
    .pos_q     (flt_lvl[0]),
    .neg_q     (flt_lvl[1]),
    .run_q     (flt_lvl[2])
);

// File: tb/sim_gcq_top.sv
`timescale 1ns/1ps
module sim_gcq_top;

    localparam int L    = 4;  // FILT_LEN
    localparam int LE   = 4;  // EN_FILT_LEN
    localparam int LAT  = L + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    // undriven defaults: pos low, neg high -> off
    logic in_pos = 1'b0;
    logic in_neg = 1'b1;
    logic shutdown_n = 1'b1;
    logic force_off = 1'b0;
    logic gate_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gcq_top #(.FILT_LEN(L), .EN_FILT_LEN(LE), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_pos(in_pos), .in_neg(in_neg),
        .shutdown_n(shutdown_n), .force_off(force_off), .gate_on(gate_on)
    );

    // ---------- bench model from the requirements ----------
    logic [2:0] m_s1, m_s2, m_q;
    int         m_run [3];
    int         m_st;   // 0 off, 1 on, 2 forced

    function automatic int ch_len(int i);
        return (i == 2) ? LE : L;
    endfunction

    function automatic bit want(logic [2:0] q);
        return q[0] && !q[1] && q[2];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 3'b010; m_s2 <= 3'b010; m_q <= 3'b010;
            for (int i = 0; i < 3; i++) m_run[i] <= 0;
            m_st <= 0;
        end else begin
            m_s1 <= {shutdown_n, in_neg, in_pos};
            m_s2 <= m_s1;
            for (int i = 0; i < 3; i++) begin
                if (m_s2[i] == m_q[i]) m_run[i] <= 0;
                else if (m_run[i] + 1 >= ch_len(i)) begin
                    m_q[i] <= m_s2[i];
                    m_run[i] <= 0;
                end else m_run[i] <= m_run[i] + 1;
            end
            if (force_off) m_st <= 2;
            else if (m_st == 2) m_st <= 0;
            else if (m_st == 0 && want(m_q)) m_st <= 1;
            else if (m_st == 1 && !want(m_q)) m_st <= 0;
        end
    end

    task automatic check(bit ok, string tag, logic act, logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: gate_on=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock; sample at the falling edge and compare to the model
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check(gate_on === (m_st == 1), "R1 R3 model", gate_on, m_st == 1);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));

        // R7: reset with on-inputs already applied
        in_pos = 1'b1; in_neg = 1'b0; shutdown_n = 1'b1;
        repeat (3) @(negedge clk);
        check(gate_on === 1'b0, "R7 reset off", gate_on, 1'b0);
        rst_n = 1'b1;
        steps(LAT - 1);
        check(gate_on === 1'b0, "R7 not before latency", gate_on, 1'b0);
        step();
        check(gate_on === 1'b1, "R7 on at latency", gate_on, 1'b1);

        // R3 latency of falling command, non-inverting mode (R2)
        in_pos = 1'b0;
        steps(LAT - 1);
        check(gate_on === 1'b1, "R2 R3 still on", gate_on, 1'b1);
        step();
        check(gate_on === 1'b0, "R2 R3 off at latency", gate_on, 1'b0);

        // R3: pulse of L-1 suppressed
        in_pos = 1'b1; steps(L - 1); in_pos = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 12; i++) begin step(); if (gate_on) seen = 1'b1; end
            check(!seen, "R3 short pulse suppressed", seen, 1'b0);
        end
        // R3: pulse of exactly L accepted
        in_pos = 1'b1; steps(L); in_pos = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 12; i++) begin step(); if (gate_on) seen = 1'b1; end
            check(seen, "R3 full pulse accepted", seen, 1'b1);
        end

        // R8: interrupted run restarts count
        in_pos = 1'b1; steps(L - 1); in_pos = 1'b0; step();
        in_pos = 1'b1; steps(L - 1); in_pos = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 12; i++) begin step(); if (gate_on) seen = 1'b1; end
            check(!seen, "R8 count restarts", seen, 1'b0);
        end

        // R2 inverting mode: pos tied high, neg drives
        in_neg = 1'b1; in_pos = 1'b1; steps(12);
        check(gate_on === 1'b0, "R2 inverting off", gate_on, 1'b0);
        in_neg = 1'b0;
        steps(LAT - 1);
        check(gate_on === 1'b0, "R2 inverting before latency", gate_on, 1'b0);
        step();
        check(gate_on === 1'b1, "R2 inverting on", gate_on, 1'b1);

        // R4: short shutdown pulse ignored, long one turns off
        shutdown_n = 1'b0; steps(LE - 1); shutdown_n = 1'b1;
        begin
            bit dropped = 1'b0;
            for (int i = 0; i < 12; i++) begin step(); if (!gate_on) dropped = 1'b1; end
            check(!dropped, "R4 shutdown glitch ignored", !dropped, 1'b1);
        end
        shutdown_n = 1'b0; steps(LE + 3);
        check(gate_on === 1'b0, "R4 shutdown off", gate_on, 1'b0);
        shutdown_n = 1'b1; steps(LE + 3);
        check(gate_on === 1'b1, "R4 resumes", gate_on, 1'b1);

        // R5 / R6: one-cycle force-off
        force_off = 1'b1; step();
        check(gate_on === 1'b0, "R5 force off immediate", gate_on, 1'b0);
        force_off = 1'b0; step();
        check(gate_on === 1'b0, "R6 extra off cycle", gate_on, 1'b0);
        step();
        check(gate_on === 1'b1, "R6 back on", gate_on, 1'b1);

        // random: non-inverting, inverting, then free
        for (int seg = 0; seg < 3; seg++) begin
            for (int c = 0; c < 1000; c++) begin
                if (seg == 0) in_neg = 1'b0;
                else if ($urandom_range(3) == 0) in_neg = ~in_neg;
                if (seg == 1) in_pos = 1'b1;
                else if ($urandom_range(3) == 0) in_pos = ~in_pos;
                if ($urandom_range(15) == 0) shutdown_n = ~shutdown_n;
                force_off = ($urandom_range(31) == 0);
                step();
            end
        end
        force_off = 1'b0;

        done = 1'b1;
        finish_run();
    end

endmodule